// File: doc/BRIEF.md
# Access-Typed Direct-Mapped Address Translation Cache

This block turns virtual addresses into physical addresses for 8 KiB pages. It keeps 256 direct-mapped slots. Each slot holds one physical page base and three independent tags, one for each kind of access: instruction fetch, data load and data store. A request hits only when the tag for its own access kind matches. A page therefore serves exactly the kinds of access whose permission was confirmed when the slot was filled.

On a miss the block stalls the requester and asks an external page walker for the page-table entry of the virtual page. When the entry comes back, the block writes it into the slot and validates only the tags that the entry's permission bits allow at the requester's privilege level. One cycle later it completes the request, either with a physical address or with a fault. The block also owns the page-table base register that the walker reads. Writing that register clears every slot, and so does an explicit flush.

The requester holds `req_valid` and the request fields steady until `done` is high.

Top module: `xlat_cache`

## Requirements
- R1: The low 13 virtual address bits form the page offset. On a hit in the idle state, `done` is high in the same cycle as the request, `fault` is low, and `paddr` is the stored page base (PTE bits 31:13) followed by the 13 offset bits.
- R2: The slot index is the virtual page number (`req_vaddr[31:13]`) modulo 256. A hit needs all 19 virtual page number bits to equal the stored tag, so two pages that share an index but differ in tag displace each other.
- R3: The tag set used for a lookup follows a fixed priority: fetch when `req_fetch` is high, otherwise store when `req_store` is high, otherwise load.
- R4: On a miss, `stall` is high in the request cycle. From the next cycle `walk_req_valid` is high, with `walk_vpn` equal to the virtual page number, and both hold until `walk_rsp_valid` arrives.
- R5: The cycle after the walk response, `done` is high and `paddr` is formed from the returned PTE.
- R6: A refill validates a kind's tag only when PTE bit 1 (leaf) is set and the kind's permission bit is set, and it invalidates the other tags of that slot. The permission bits are: supervisor read bit 9, write bit 8, execute bit 7; user read bit 6, write bit 5, execute bit 4. Supervisor or user is taken from `req_super` at the time of the miss.
- R7: When the refilled entry does not validate the requesting kind, the completion cycle shows `done` and `fault` both high.
- R8: A `flush` pulse invalidates every tag of every slot from the next cycle on.
- R9: Writing `ptbr_wdata` with `ptbr_we` loads `ptbr_q` with the low 13 bits forced to zero, and it invalidates every slot.
- R10: A walk response that arrives in the same cycle as a flush is discarded. The block returns to idle and retries the held request, which misses again.
- R11: After reset no slot is valid, `ptbr_q` is zero, and `done`, `fault`, `stall` and `walk_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present, held until done |
| req_vaddr | input | 32 | Virtual address |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_store | input | 1 | Request is a store |
| req_super | input | 1 | Requester runs in supervisor mode |
| done | output | 1 | Request completes this cycle |
| fault | output | 1 | Completing request has no permission |
| stall | output | 1 | Request is waiting on a refill |
| paddr | output | 32 | Translated physical address |
| walk_req_valid | output | 1 | Page walk requested |
| walk_vpn | output | 19 | Virtual page number to walk |
| walk_rsp_valid | input | 1 | Walk response present |
| walk_rsp_pte | input | 32 | Returned page-table entry |
| flush | input | 1 | Invalidate all slots |
| ptbr_we | input | 1 | Write page-table base |
| ptbr_wdata | input | 32 | New page-table base |
| ptbr_q | output | 32 | Current page-table base, page-aligned |

## Verification
The hardest case to reach from the ports is a single slot whose three tags disagree: one kind is valid and another kind, on the same page, is not. The stimulus creates this by refilling a page through one kind with a PTE that lacks another kind's permission bit, and then requesting the missing kind on the same address, also with fetch and store raised together. A second hard case is a walk response that lands exactly on a flush. The bench holds the walk pending and drives the response and the flush in the same cycle, then watches the held request miss again.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } xl_state_e;

  localparam int unsigned NUM_ACC   = 3;
  localparam int unsigned PERM_W    = 10;
  localparam int unsigned B_LEAF    = 1;
  localparam int unsigned B_U_EXEC  = 4;
  localparam int unsigned B_U_WRITE = 5;
  localparam int unsigned B_U_READ  = 6;
  localparam int unsigned B_S_EXEC  = 7;
  localparam int unsigned B_S_WRITE = 8;
  localparam int unsigned B_S_READ  = 9;

  // whether a PTE's low bits let access kind `kind` through at privilege `sup`
  function automatic logic pte_grants(input logic [PERM_W-1:0] lo,
                                      input int unsigned kind,
                                      input logic sup);
    logic rd, wr, ex;
    rd = sup ? lo[B_S_READ]  : lo[B_U_READ];
    wr = sup ? lo[B_S_WRITE] : lo[B_U_WRITE];
    ex = sup ? lo[B_S_EXEC]  : lo[B_U_EXEC];
    case (kind)
      0:       return lo[B_LEAF] & rd;
      1:       return lo[B_LEAF] & wr;
      default: return lo[B_LEAF] & ex;
    endcase
  endfunction

endpackage

// File: rtl/xlat_tag_bank.sv
module xlat_tag_bank #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned VPN_W   = 19,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             rd_hit
);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [IDX_W-1:0]   wr_idx, rd_idx;

  assign wr_idx = wr_vpn[IDX_W-1:0];
  assign rd_idx = rd_vpn[IDX_W-1:0];

  always_comb begin
    valid_d = valid_q;
    if (flush)
      valid_d = '0;
    else if (wr_en)
      valid_d[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= '0;
    else
      valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      tag_q[wr_idx] <= wr_vpn;
  end

  assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_vpn);

endmodule

// File: rtl/xlat_ppn_store.sv
module xlat_ppn_store #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned PPN_W   = 19,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PPN_W-1:0] rd_ppn
);

  logic [PPN_W-1:0] ppn_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en)
      ppn_q[wr_idx] <= wr_ppn;
  end

  assign rd_ppn = ppn_q[rd_idx];

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit,
  input  logic flush_all,
  input  logic rsp_valid,
  output logic done,
  output logic fault,
  output logic stall,
  output logic capture,
  output logic refill_we,
  output logic walk_active
);

  xl_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    done      = 1'b0;
    fault     = 1'b0;
    stall     = 1'b0;
    capture   = 1'b0;
    refill_we = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (hit) begin
            done = 1'b1;
          end else begin
            stall   = 1'b1;
            capture = 1'b1;
            st_d    = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        stall = 1'b1;
        if (rsp_valid) begin
          if (flush_all) begin
            st_d = ST_IDLE;  // stale response dropped, request retried
          end else begin
            refill_we = 1'b1;
            st_d      = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        done  = 1'b1;
        fault = !hit;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= ST_IDLE;
    else
      st_q <= st_d;
  end

  assign walk_active = (st_q == ST_WAIT);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PG_SHIFT = 13,
  parameter int unsigned ENTRIES  = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic                     req_fetch,
  input  logic                     req_store,
  input  logic                     req_super,
  output logic                     done,
  output logic                     fault,
  output logic                     stall,
  output logic [PA_W-1:0]          paddr,
  output logic                     walk_req_valid,
  output logic [VA_W-PG_SHIFT-1:0] walk_vpn,
  input  logic                     walk_rsp_valid,
  input  logic [PA_W-1:0]          walk_rsp_pte,
  input  logic                     flush,
  input  logic                     ptbr_we,
  input  logic [PA_W-1:0]          ptbr_wdata,
  output logic [PA_W-1:0]          ptbr_q
);

  localparam int unsigned VPN_W = VA_W - PG_SHIFT;
  localparam int unsigned PPN_W = PA_W - PG_SHIFT;
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam logic [PA_W-1:0] OFS_MASK = PA_W'((64'd1 << PG_SHIFT) - 64'd1);

  acc_e               kind;
  logic [VPN_W-1:0]   rd_vpn;
  logic [NUM_ACC-1:0] bank_hit;
  logic               hit;
  logic               flush_all;
  logic               capture, refill_we;
  logic [VPN_W-1:0]   vpn_q, vpn_d;
  logic               sup_q, sup_d;
  logic [PA_W-1:0]    ptbr_d;
  logic [PPN_W-1:0]   rd_ppn;
  logic               unused_pte_bits;

  assign rd_vpn    = req_vaddr[VA_W-1:PG_SHIFT];
  assign flush_all = flush | ptbr_we;
  assign unused_pte_bits = ^walk_rsp_pte[PG_SHIFT-1:PERM_W];

  // fetch outranks store, store outranks load
  always_comb begin
    if (req_fetch)      kind = ACC_FETCH;
    else if (req_store) kind = ACC_STORE;
    else                kind = ACC_LOAD;
  end

  always_comb begin
    case (kind)
      ACC_FETCH: hit = bank_hit[2];
      ACC_STORE: hit = bank_hit[1];
      default:   hit = bank_hit[0];
    endcase
  end

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_bank
    logic grant;
    assign grant = pte_grants(walk_rsp_pte[PERM_W-1:0], k, sup_q);
    xlat_tag_bank #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush_all),
      .wr_en    (refill_we),
      .wr_vpn   (vpn_q),
      .wr_valid (grant),
      .rd_vpn   (rd_vpn),
      .rd_hit   (bank_hit[k])
    );
  end

  xlat_ppn_store #(
    .ENTRIES (ENTRIES),
    .PPN_W   (PPN_W)
  ) u_ppn (
    .clk    (clk),
    .wr_en  (refill_we),
    .wr_idx (vpn_q[IDX_W-1:0]),
    .wr_ppn (walk_rsp_pte[PA_W-1:PG_SHIFT]),
    .rd_idx (rd_vpn[IDX_W-1:0]),
    .rd_ppn (rd_ppn)
  );

  xlat_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .hit         (hit),
    .flush_all   (flush_all),
    .rsp_valid   (walk_rsp_valid),
    .done        (done),
    .fault       (fault),
    .stall       (stall),
    .capture     (capture),
    .refill_we   (refill_we),
    .walk_active (walk_req_valid)
  );

  // miss context and base register: next state
  always_comb begin
    vpn_d  = capture ? rd_vpn : vpn_q;
    sup_d  = capture ? req_super : sup_q;
    ptbr_d = ptbr_we ? (ptbr_wdata & ~OFS_MASK) : ptbr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      sup_q  <= 1'b0;
      ptbr_q <= '0;
    end else begin
      vpn_q  <= vpn_d;
      sup_q  <= sup_d;
      ptbr_q <= ptbr_d;
    end
  end

  assign walk_vpn = vpn_q;
  assign paddr    = {rd_ppn, req_vaddr[PG_SHIFT-1:0]};

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PG_SHIFT = 13
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     done,
  input logic                     fault,
  input logic                     stall,
  input logic                     walk_req_valid,
  input logic [VA_W-PG_SHIFT-1:0] walk_vpn,
  input logic                     ptbr_we,
  input logic [PA_W-1:0]          ptbr_wdata,
  input logic [PA_W-1:0]          ptbr_q
);

  localparam logic [PA_W-1:0] LOW_MASK = PA_W'((64'd1 << PG_SHIFT) - 64'd1);

  // R4: a pending walk keeps the requester stalled and never completes it
  a_r4_walk_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> (stall && !done));

  // R4: the walked page number holds while the walk is outstanding
  a_r4_vpn_held: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && $past(walk_req_valid)) |-> $stable(walk_vpn));

  // R5: completion and stall are exclusive
  a_r5_done_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall);

  // R7: a fault only appears on a completing request
  a_r7_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  // R9: a base write lands page-aligned on the next cycle
  a_r9_ptbr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ptbr_we |=> (ptbr_q == ($past(ptbr_wdata) & ~LOW_MASK)));

endmodule

bind xlat_cache xlat_cache_chk #(
  .VA_W     (VA_W),
  .PA_W     (PA_W),
  .PG_SHIFT (PG_SHIFT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .done           (done),
  .fault          (fault),
  .stall          (stall),
  .walk_req_valid (walk_req_valid),
  .walk_vpn       (walk_vpn),
  .ptbr_we        (ptbr_we),
  .ptbr_wdata     (ptbr_wdata),
  .ptbr_q         (ptbr_q)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;

  localparam logic [31:0] LEAF = 32'h002;
  localparam logic [31:0] TDESC = 32'h001;
  localparam logic [31:0] UX = 32'h010, UW = 32'h020, UR = 32'h040;
  localparam logic [31:0] SX = 32'h080, SW = 32'h100, SR = 32'h200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_fetch, req_store, req_super;
  logic [31:0] req_vaddr;
  logic        done, fault, stall, walk_req_valid;
  logic [31:0] paddr;
  logic [18:0] walk_vpn;
  logic        walk_rsp_valid;
  logic [31:0] walk_rsp_pte;
  logic        flush, ptbr_we;
  logic [31:0] ptbr_wdata, ptbr_q;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_fetch(req_fetch), .req_store(req_store), .req_super(req_super),
    .done(done), .fault(fault), .stall(stall), .paddr(paddr),
    .walk_req_valid(walk_req_valid), .walk_vpn(walk_vpn),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pte(walk_rsp_pte),
    .flush(flush), .ptbr_we(ptbr_we), .ptbr_wdata(ptbr_wdata), .ptbr_q(ptbr_q)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(input logic [18:0] ppn, input logic [31:0] bits);
    return {ppn, 13'h0} | bits;
  endfunction

  // One translation. On a miss the walk is answered with `pte`.
  task automatic access(input logic [31:0] va, input logic f, input logic s,
                        input logic sup, input bit exp_hit, input logic [18:0] hit_ppn,
                        input logic [31:0] pte, input bit exp_fault, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_fetch = f; req_store = s; req_super = sup;
    #5;
    chk((done && !stall) == exp_hit, req, "hit", {31'd0, done}, {31'd0, exp_hit});
    if (done && !stall) begin
      chk(paddr == {hit_ppn, va[12:0]}, req, "hit paddr", paddr, {hit_ppn, va[12:0]});
      chk(!fault, req, "hit fault", {31'd0, fault}, 32'd0);
    end else begin
      @(negedge clk); #5;
      chk(walk_req_valid && walk_vpn == va[31:13], req, "walk vpn",
          {13'd0, walk_vpn}, {13'd0, va[31:13]});
      walk_rsp_valid = 1'b1; walk_rsp_pte = pte;
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      #5;
      chk(done && !walk_req_valid, req, "refill done", {31'd0, done}, 32'd1);
      chk(fault == exp_fault, req, "fault", {31'd0, fault}, {31'd0, exp_fault});
      if (!exp_fault)
        chk(paddr == {pte[31:13], va[12:0]}, req, "refill paddr", paddr, {pte[31:13], va[12:0]});
    end
    @(negedge clk);
    req_valid = 1'b0; req_fetch = 1'b0; req_store = 1'b0;
  endtask

  localparam logic [31:0] VA_A = 32'h0012_3456;
  localparam logic [31:0] VA_B = 32'h00AB_C024;
  localparam logic [31:0] VA_C = VA_A + (32'd256 << 13);
  localparam logic [31:0] VA_D = 32'h0700_1ABC;
  localparam logic [31:0] VA_E = 32'h0300_0100;
  localparam logic [18:0] P_A = 19'h45678, P_B = 19'h01234, P_C = 19'h7_0F0F;
  localparam logic [18:0] P_D = 19'h0_2222, P_E = 19'h3_3333;

  task automatic t_reset();
    #5;
    chk(!done && !stall && !walk_req_valid && !fault, "R11", "idle outputs",
        {28'd0, done, stall, walk_req_valid, fault}, 32'd0);
    chk(ptbr_q == 32'd0, "R11", "ptbr after reset", ptbr_q, 32'd0);
    // nothing is valid: first load misses (R11) and is served by refill (R4, R5)
    access(VA_A, 0, 0, 1, 0, P_A, mk_pte(P_A, LEAF | SR | SW), 0, "R11");
  endtask

  task automatic t_hits();
    access(VA_A, 0, 0, 1, 1, P_A, 32'h0, 0, "R1");
    access(VA_A + 32'h0BA0, 0, 0, 1, 1, P_A, 32'h0, 0, "R1");
    access(VA_A, 0, 1, 1, 1, P_A, 32'h0, 0, "R6");   // store granted by SW
  endtask

  task automatic t_kind_split();
    // fetch has no execute bit: separate tag misses, refill faults
    access(VA_A, 1, 0, 1, 0, P_A, mk_pte(P_A, LEAF | SR | SW), 1, "R7");
    access(VA_A, 0, 0, 1, 1, P_A, 32'h0, 0, "R6");
    access(VA_A, 1, 0, 1, 0, P_A, mk_pte(P_A, LEAF | SR), 1, "R6");
    access(VA_A, 0, 1, 1, 0, P_A, mk_pte(P_A, LEAF | SR | SW), 0, "R6"); // store tag dropped
  endtask

  task automatic t_priority();
    access(VA_B, 0, 1, 1, 0, P_B, mk_pte(P_B, LEAF | SW | SR), 0, "R3");
    // fetch + store: fetch tag rules and it is invalid
    access(VA_B, 1, 1, 1, 0, P_B, mk_pte(P_B, LEAF | SX | SW | SR), 0, "R3");
    access(VA_B, 1, 1, 1, 1, P_B, 32'h0, 0, "R3");
    access(VA_B, 0, 1, 1, 1, P_B, 32'h0, 0, "R3");
  endtask

  task automatic t_alias();
    access(VA_A, 0, 0, 1, 1, P_A, 32'h0, 0, "R2");
    access(VA_C, 0, 0, 1, 0, P_C, mk_pte(P_C, LEAF | SR), 0, "R2");
    access(VA_C, 0, 0, 1, 1, P_C, 32'h0, 0, "R2");
    access(VA_A, 0, 0, 1, 0, P_A, mk_pte(P_A, LEAF | SR | SW), 0, "R2");
  endtask

  task automatic t_privilege();
    access(VA_D, 0, 0, 0, 0, P_D, mk_pte(P_D, LEAF | SR | SW | SX), 1, "R6");
    access(VA_D, 0, 0, 1, 0, P_D, mk_pte(P_D, LEAF | UR), 1, "R6");
    access(VA_D, 0, 0, 0, 0, P_D, mk_pte(P_D, LEAF | UR | UX), 0, "R6");
    access(VA_D, 1, 0, 0, 1, P_D, 32'h0, 0, "R6");
    access(VA_E, 0, 0, 1, 0, P_E, mk_pte(P_E, TDESC | SR | SW | SX), 1, "R6"); // not a leaf
  endtask

  task automatic t_flush();
    access(VA_A, 0, 0, 1, 1, P_A, 32'h0, 0, "R8");
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    access(VA_A, 0, 0, 1, 0, P_A, mk_pte(P_A, LEAF | SR), 0, "R8");
    access(VA_B, 0, 1, 1, 0, P_B, mk_pte(P_B, LEAF | SW), 0, "R8");
  endtask

  task automatic t_ptbr();
    @(negedge clk); ptbr_we = 1'b1; ptbr_wdata = 32'hDEAD_BEEF;
    @(negedge clk); ptbr_we = 1'b0;
    #5;
    chk(ptbr_q == 32'hDEAD_A000, "R9", "ptbr aligned", ptbr_q, 32'hDEAD_A000);
    access(VA_A, 0, 0, 1, 0, P_A, mk_pte(P_A, LEAF | SR), 0, "R9");
  endtask

  task automatic t_flush_race();
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = VA_C; req_fetch = 0; req_store = 0; req_super = 1;
    #5;
    chk(stall && !done, "R10", "initial miss", {31'd0, stall}, 32'd1);
    @(negedge clk);
    walk_rsp_valid = 1'b1; walk_rsp_pte = mk_pte(P_C, LEAF | SR); flush = 1'b1;
    @(negedge clk);
    walk_rsp_valid = 1'b0; flush = 1'b0;
    #5;
    chk(stall && !done && !walk_req_valid, "R10", "retry misses again",
        {29'd0, stall, done, walk_req_valid}, 32'd4);
    @(negedge clk); #5;
    chk(walk_req_valid && walk_vpn == VA_C[31:13], "R10", "second walk",
        {13'd0, walk_vpn}, {13'd0, VA_C[31:13]});
    walk_rsp_valid = 1'b1; walk_rsp_pte = mk_pte(P_C, LEAF | SR);
    @(negedge clk);
    walk_rsp_valid = 1'b0;
    #5;
    chk(done && !fault && paddr == {P_C, VA_C[12:0]}, "R10", "completion", paddr, {P_C, VA_C[12:0]});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; req_fetch = 0; req_store = 0; req_super = 0;
    req_vaddr = '0; walk_rsp_valid = 0; walk_rsp_pte = '0; flush = 0;
    ptbr_we = 0; ptbr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hits();
    t_kind_split();
    t_priority();
    t_alias();
    t_privilege();
    t_flush();
    t_ptbr();
    t_flush_race();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule